// File: doc/BRIEF.md
# Load/Store Data Comparator

This block watches the integer data of load and store accesses and raises a match event whenever that data stands in a chosen relation to a programmed reference value. Each comparator is set up with its own reference, operand size (byte, half-word, word or full bus width), signedness and relation (equal, not equal, greater than, less than). The events it produces feed the load/store watchpoint combining logic that sits downstream.

For every access the block takes the data bus, a byte offset that says which lane carries a narrow operand, and a strobe that marks the cycle as a real access. A narrow operand is pulled out of its lane and widened by sign or zero extension, as the signedness setting asks. The reference is narrowed to its own low-order bits of the same size and widened the same way. The extended values are then ordered as signed numbers one bit wider than the bus, which gives unsigned or signed ordering from a single comparator. The events come out of a register one cycle after the access.

Top module: `ldst_data_cmp`

## Requirements
- R1: `match_evt[i]` is registered: it shows the result for the access presented in the previous clock cycle, and it is 0 in any cycle after one in which `acc_valid` was low.
- R2: The operand size field of a comparator encodes 0 = byte, 1 = half-word, 2 = word (32 bits), 3 = full data width (the same as a word when the data width is 32).
- R3: For a byte, the operand is `acc_data[8*off+7:8*off]`, where `off` is `acc_lane`. For a half-word, it is `acc_data[16*h+15:16*h]` with `h = acc_lane[LANE_W-1:1]`, and `acc_lane[0]` is ignored. For word and full sizes at a 32-bit bus, the lane offset is ignored.
- R4: The reference is the low-order byte, half-word or word of the comparator's reference field, chosen to match the operand size. Its higher bits have no effect.
- R5: With the signed bit at 1, both values are sign-extended and ordered as two's-complement numbers. With it at 0, they are zero-extended and ordered as unsigned numbers.
- R6: The condition field encodes 0 = equal, 1 = not equal, 2 = data greater than reference, 3 = data less than reference. Greater-than and less-than are strict.
- R7: The comparators are independent of each other. Bit i of `match_evt` depends only on the access inputs and on comparator i's own reference, size, signedness and condition fields.
- R8: While `rst_n` is low, and in the first cycle after it rises, `match_evt` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | High in a cycle that carries a load or store access |
| acc_data | input | DATA_W | Load or store integer data |
| acc_lane | input | LANE_W | Byte offset of a narrow operand within the data bus |
| cfg_ref | input | NUM_CMP*DATA_W | Reference value per comparator; comparator i uses bits [i*DATA_W +: DATA_W] |
| cfg_size | input | NUM_CMP*2 | Operand size per comparator; comparator i uses bits [2*i +: 2] |
| cfg_signed | input | NUM_CMP | Signed ordering per comparator |
| cfg_cond | input | NUM_CMP*2 | Relation per comparator; comparator i uses bits [2*i +: 2] |
| match_evt | output | NUM_CMP | Registered match event per comparator |

## Verification
The bench builds the block with its default values: a 32-bit data bus, so LANE_W is 2, and two comparators. With these values, all four byte lanes and both half-word lanes can be reached. So can the alias of size 3 onto the word size, and the case where two comparators with different settings judge the same access in the same cycle. Directed cycles cover the signed and unsigned extremes of each lane (0x80 and 0x7F bytes, 0x8000 halves), equal operands under the strict relations, and reference bits above the operand size. A long run of random accesses follows, with the reference often forced to equal the selected lane, and every cycle is compared against the model.

// File: rtl/ldcmp_pkg.sv
package ldcmp_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_FULL = 2'd3
   } opsize_e;

   typedef enum logic [1:0] {
      CC_EQ = 2'd0,
      CC_NE = 2'd1,
      CC_GT = 2'd2,
      CC_LT = 2'd3
   } cond_e;

   typedef struct packed {
      logic eq;
      logic lt;
   } relation_t;

endpackage

// File: rtl/ldcmp_operand.sv
// Pulls the operand out of its lane and widens it to DATA_W+1 bits.
module ldcmp_operand
   import ldcmp_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int LANE_W = $clog2(DATA_W / 8)
) (
   input  logic [DATA_W-1:0] data,
   input  logic [LANE_W-1:0] lane,
   input  opsize_e           size,
   input  logic              sgn,
   output logic [DATA_W:0]   ext
);

   localparam int EXT_W = DATA_W + 1;

   logic [DATA_W-1:0] byte_sh;
   logic [DATA_W-1:0] half_sh;
   logic [7:0]        op_b;
   logic [15:0]       op_h;
   logic [31:0]       op_w;

   assign byte_sh = data >> {lane, 3'b000};
   assign half_sh = data >> {lane[LANE_W-1:1], 4'b0000};
   assign op_b    = byte_sh[7:0];
   assign op_h    = half_sh[15:0];

   generate
      if (DATA_W == 32) begin : g_word_whole
         assign op_w = data;
      end else begin : g_word_lane
         logic [DATA_W-1:0] word_sh;
         assign word_sh = data >> {lane[LANE_W-1:2], 5'b00000};
         assign op_w    = word_sh[31:0];
      end
   endgenerate

   always_comb begin
      unique case (size)
         SZ_BYTE: ext = sgn ? {{(EXT_W-8){op_b[7]}}, op_b}
                            : {{(EXT_W-8){1'b0}}, op_b};
         SZ_HALF: ext = sgn ? {{(EXT_W-16){op_h[15]}}, op_h}
                            : {{(EXT_W-16){1'b0}}, op_h};
         SZ_WORD: ext = sgn ? {{(EXT_W-32){op_w[31]}}, op_w}
                            : {{(EXT_W-32){1'b0}}, op_w};
         default: ext = sgn ? {data[DATA_W-1], data}
                            : {1'b0, data};
      endcase
   end

endmodule

// File: rtl/ldcmp_relate.sv
// Signed ordering of two extended operands.
module ldcmp_relate
   import ldcmp_pkg::*;
#(
   parameter int EXT_W = 33
) (
   input  logic [EXT_W-1:0] lhs,
   input  logic [EXT_W-1:0] rhs,
   output relation_t        rel
);

   assign rel.eq = (lhs == rhs);
   assign rel.lt = ($signed(lhs) < $signed(rhs));

endmodule

// File: rtl/ldcmp_unit.sv
// One comparator: operand and reference shaping, relation, condition, register.
module ldcmp_unit
   import ldcmp_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int LANE_W = $clog2(DATA_W / 8)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic [DATA_W-1:0] acc_data,
   input  logic [LANE_W-1:0] acc_lane,
   input  logic [DATA_W-1:0] ref_val,
   input  logic [1:0]        size_raw,
   input  logic              sgn,
   input  logic [1:0]        cond_raw,
   output logic              hit_q
);

   localparam int EXT_W = DATA_W + 1;

   opsize_e          size;
   cond_e            cond;
   logic [EXT_W-1:0] data_ext;
   logic [EXT_W-1:0] ref_ext;
   relation_t        rel;
   logic             hit;

   assign size = opsize_e'(size_raw);
   assign cond = cond_e'(cond_raw);

   ldcmp_operand #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_dat (
      .data (acc_data),
      .lane (acc_lane),
      .size (size),
      .sgn  (sgn),
      .ext  (data_ext)
   );

   ldcmp_operand #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_ref (
      .data (ref_val),
      .lane ({LANE_W{1'b0}}),
      .size (size),
      .sgn  (sgn),
      .ext  (ref_ext)
   );

   ldcmp_relate #(.EXT_W(EXT_W)) u_rel (
      .lhs (data_ext),
      .rhs (ref_ext),
      .rel (rel)
   );

   always_comb begin
      unique case (cond)
         CC_EQ:   hit = rel.eq;
         CC_NE:   hit = !rel.eq;
         CC_GT:   hit = !rel.eq && !rel.lt;
         default: hit = rel.lt;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hit_q <= 1'b0;
      else        hit_q <= acc_valid && hit;
   end

endmodule

// File: rtl/ldst_data_cmp.sv
module ldst_data_cmp
   import ldcmp_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int NUM_CMP = 2,
   parameter int LANE_W  = $clog2(DATA_W / 8)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      acc_valid,
   input  logic [DATA_W-1:0]         acc_data,
   input  logic [LANE_W-1:0]         acc_lane,
   input  logic [NUM_CMP*DATA_W-1:0] cfg_ref,
   input  logic [NUM_CMP*2-1:0]      cfg_size,
   input  logic [NUM_CMP-1:0]        cfg_signed,
   input  logic [NUM_CMP*2-1:0]      cfg_cond,
   output logic [NUM_CMP-1:0]        match_evt
);

   generate
      if (DATA_W != 32 && DATA_W != 64) begin : g_bad_width
         $error("ldst_data_cmp: DATA_W must be 32 or 64");
      end
      if (NUM_CMP < 1) begin : g_bad_count
         $error("ldst_data_cmp: NUM_CMP must be at least 1");
      end
      if (LANE_W != $clog2(DATA_W / 8)) begin : g_bad_lane
         $error("ldst_data_cmp: LANE_W must match DATA_W");
      end
   endgenerate

   for (genvar gi = 0; gi < NUM_CMP; gi++) begin : g_cmp
      ldcmp_unit #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_unit (
         .clk       (clk),
         .rst_n     (rst_n),
         .acc_valid (acc_valid),
         .acc_data  (acc_data),
         .acc_lane  (acc_lane),
         .ref_val   (cfg_ref[gi*DATA_W +: DATA_W]),
         .size_raw  (cfg_size[2*gi +: 2]),
         .sgn       (cfg_signed[gi]),
         .cond_raw  (cfg_cond[2*gi +: 2]),
         .hit_q     (match_evt[gi])
      );
   end

endmodule

// File: rtl/ldst_data_cmp_chk.sv
module ldst_data_cmp_chk #(
   parameter int DATA_W  = 32,
   parameter int NUM_CMP = 2
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      acc_valid,
   input logic [DATA_W-1:0]         acc_data,
   input logic [NUM_CMP*DATA_W-1:0] cfg_ref,
   input logic [NUM_CMP*2-1:0]      cfg_size,
   input logic [NUM_CMP-1:0]        cfg_signed,
   input logic [NUM_CMP*2-1:0]      cfg_cond,
   input logic [NUM_CMP-1:0]        match_evt
);

   for (genvar gi = 0; gi < NUM_CMP; gi++) begin : g_chk
      logic [DATA_W-1:0] rv;
      logic              full_sz;
      assign rv      = cfg_ref[gi*DATA_W +: DATA_W];
      assign full_sz = (cfg_size[2*gi +: 2] == 2'd3);

      // R1
      valid_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !acc_valid |=> !match_evt[gi]);

      // R6
      full_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (acc_valid && full_sz && cfg_cond[2*gi +: 2] == 2'd0 && acc_data == rv)
         |=> match_evt[gi]);

      // R6
      ne_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (full_sz && cfg_cond[2*gi +: 2] == 2'd1 && acc_data == rv)
         |=> !match_evt[gi]);

      // R6
      strict_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (full_sz && cfg_cond[2*gi + 1] && acc_data == rv)
         |=> !match_evt[gi]);

      // R5
      uns_gt_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (acc_valid && full_sz && !cfg_signed[gi] && cfg_cond[2*gi +: 2] == 2'd2
          && acc_data > rv) |=> match_evt[gi]);

      // R5
      sgn_lt_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (acc_valid && full_sz && cfg_signed[gi] && cfg_cond[2*gi +: 2] == 2'd3
          && $signed(acc_data) < $signed(rv)) |=> match_evt[gi]);
   end

endmodule

bind ldst_data_cmp ldst_data_cmp_chk #(.DATA_W(DATA_W), .NUM_CMP(NUM_CMP)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .acc_valid  (acc_valid),
   .acc_data   (acc_data),
   .cfg_ref    (cfg_ref),
   .cfg_size   (cfg_size),
   .cfg_signed (cfg_signed),
   .cfg_cond   (cfg_cond),
   .match_evt  (match_evt)
);

// File: tb/sim_ldst_data_cmp.sv
`timescale 1ns/1ps
module sim_ldst_data_cmp;

   localparam int DW = 32;
   localparam int NC = 2;
   localparam int LW = 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             acc_valid = 1'b0;
   logic [DW-1:0]    acc_data = '0;
   logic [LW-1:0]    acc_lane = '0;
   logic [NC*DW-1:0] cfg_ref = '0;
   logic [NC*2-1:0]  cfg_size = '0;
   logic [NC-1:0]    cfg_signed = '0;
   logic [NC*2-1:0]  cfg_cond = '0;
   logic [NC-1:0]    match_evt;

   int    checks = 0;
   int    errors = 0;
   bit    exp_q [NC];
   string tag_q [NC];

   always #2 clk = ~clk;

   ldst_data_cmp #(.DATA_W(DW), .NUM_CMP(NC)) u0 (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_data(acc_data),
      .acc_lane(acc_lane), .cfg_ref(cfg_ref), .cfg_size(cfg_size),
      .cfg_signed(cfg_signed), .cfg_cond(cfg_cond), .match_evt(match_evt)
   );

   function automatic bit model(logic [31:0] d, logic [1:0] off, logic [31:0] r,
                                logic [1:0] sz, bit sg, logic [1:0] c);
      longint a, b;
      int     bits;
      case (sz)
         2'd0: begin a = longint'((d >> (8 * off)) & 32'hFF); b = longint'(r & 32'hFF); bits = 8; end
         2'd1: begin a = longint'((d >> (16 * off[1])) & 32'hFFFF); b = longint'(r & 32'hFFFF); bits = 16; end
         default: begin a = longint'(d); b = longint'(r); bits = 32; end
      endcase
      if (sg) begin
         if (a >= (64'sd1 << (bits - 1))) a = a - (64'sd1 << bits);
         if (b >= (64'sd1 << (bits - 1))) b = b - (64'sd1 << bits);
      end
      case (c)
         2'd0: return a == b;
         2'd1: return a != b;
         2'd2: return a > b;
         default: return a < b;
      endcase
   endfunction

   task automatic set_cmp(int i, logic [31:0] r, logic [1:0] sz, bit sg, logic [1:0] c);
      cfg_ref[i*DW +: DW] = r;
      cfg_size[2*i +: 2]  = sz;
      cfg_signed[i]       = sg;
      cfg_cond[2*i +: 2]  = c;
   endtask

   task automatic check_now(int i, bit exp, string tag);
      checks++;
      if (match_evt[i] !== exp) begin
         errors++;
         $display("FAIL %s cmp%0d: actual %b expected %b", tag, i, match_evt[i], exp);
      end
   endtask

   // Inputs are applied at a falling edge; the result is sampled at the next one.
   task automatic step(string tag);
      for (int i = 0; i < NC; i++) begin
         exp_q[i] = acc_valid && model(acc_data, acc_lane, cfg_ref[i*DW +: DW],
                                       cfg_size[2*i +: 2], cfg_signed[i], cfg_cond[2*i +: 2]);
         tag_q[i] = tag;
      end
      @(negedge clk);
      for (int i = 0; i < NC; i++) check_now(i, exp_q[i], tag_q[i]);
   endtask

   task automatic access(logic [31:0] d, logic [1:0] off, string tag);
      acc_valid = 1'b1;
      acc_data  = d;
      acc_lane  = off;
      step(tag);
   endtask

   initial begin
      #(4 * 200000);
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      // R8: held in reset with a configuration that would match
      set_cmp(0, 32'h0, 2'd3, 1'b0, 2'd0);
      set_cmp(1, 32'h5, 2'd3, 1'b0, 2'd1);
      acc_valid = 1'b1;
      repeat (3) @(negedge clk);
      check_now(0, 1'b0, "R8");
      check_now(1, 1'b0, "R8");
      rst_n = 1'b1;
      check_now(0, 1'b0, "R8");
      acc_valid = 1'b0;
      step("R8");

      // R1: valid low with matching data gives no event
      acc_data = 32'h0;
      acc_valid = 1'b0;
      step("R1");
      step("R1");
      access(32'h0, 2'd0, "R1");
      acc_valid = 1'b0;
      step("R1");

      // R3 R5: byte in lane 3, signed vs unsigned
      set_cmp(0, 32'h01, 2'd0, 1'b1, 2'd3);
      set_cmp(1, 32'h01, 2'd0, 1'b0, 2'd2);
      access(32'h8000_0000, 2'd3, "R5");
      for (int l = 0; l < 4; l++) access(32'h7F7F_7F7F ^ (32'hFF << (8 * l)), 2'(l), "R3");

      // R3: half-word lane, low offset bit ignored
      set_cmp(0, 32'h8000, 2'd1, 1'b1, 2'd3);
      set_cmp(1, 32'h1234, 2'd1, 1'b0, 2'd0);
      access(32'h1234_8000, 2'd2, "R3");
      access(32'h1234_8000, 2'd3, "R3");
      access(32'h1234_8000, 2'd0, "R3");
      access(32'h8000_1234, 2'd1, "R3");

      // R4: reference bits above the operand size have no effect
      set_cmp(0, 32'hFFFF_FF05, 2'd0, 1'b0, 2'd0);
      set_cmp(1, 32'hABCD_0077, 2'd1, 1'b1, 2'd0);
      access(32'h0500_0077, 2'd3, "R4");
      access(32'h0500_0077, 2'd0, "R4");

      // R2: size 3 aliases the word at this width, lane ignored
      set_cmp(0, 32'hFFFF_FFFF, 2'd3, 1'b1, 2'd2);
      set_cmp(1, 32'hFFFF_FFFF, 2'd2, 1'b0, 2'd3);
      access(32'h0000_0000, 2'd2, "R2");
      access(32'h8000_0000, 2'd1, "R2");

      // R6: strict relations on equal operands
      set_cmp(0, 32'hDEAD_BEEF, 2'd2, 1'b0, 2'd2);
      set_cmp(1, 32'hDEAD_BEEF, 2'd2, 1'b1, 2'd3);
      access(32'hDEAD_BEEF, 2'd0, "R6");
      set_cmp(0, 32'hDEAD_BEEF, 2'd2, 1'b0, 2'd1);
      set_cmp(1, 32'hDEAD_BEEF, 2'd2, 1'b1, 2'd0);
      access(32'hDEAD_BEEF, 2'd0, "R6");
      access(32'hDEAD_BEEE, 2'd0, "R6");

      // R7: random accesses with independent configurations
      for (int n = 0; n < 4000; n++) begin
         logic [31:0] d;
         logic [1:0]  off;
         d   = $urandom;
         if ($urandom % 4 == 0) d = d & 32'h8001_807F;
         off = 2'($urandom);
         for (int i = 0; i < NC; i++) begin
            logic [31:0] r;
            r = $urandom;
            if ($urandom % 3 == 0) r = (d >> (8 * off)) ^ ($urandom & 32'hFFFF_0000);
            if ($urandom % 5 == 0) r = d;
            set_cmp(i, r, 2'($urandom), 1'($urandom), 2'($urandom));
         end
         acc_valid = ($urandom % 4) != 0;
         acc_data  = d;
         acc_lane  = off;
         step("R7");
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule